// File: doc/BRIEF.md
# Shrinking bit generator

This block produces a pseudo-random bit stream by decimation. It holds two maximal-length linear-feedback shift registers. The first is a selector register. The second is a data register. Both registers advance together on every enabled clock cycle. The low bit of the selector register decides whether the data register's low bit from that cycle is passed to the output or dropped. Because of this, output bits arrive at an irregular rate, and each kept bit is marked by a valid strobe.

Both registers can be seeded at once through a load strobe. A seed of all zeros would lock a register, so such a seed is replaced by that register's nonzero default seed. Register lengths, tap masks and default seeds are parameters. Lengths that are coprime give an output period on the order of (2^A − 1)·(2^B − 1).

Top module: `shrink_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_vld` is 0. Reset puts the default seeds `SEL_SEED` and `DAT_SEED` into the selector and data registers.
- R2: A register step shifts the register one place toward bit 0. The new top bit is the XOR of the bits that the tap mask selects in the old value. The register's output bit is its bit 0.
- R3: On every cycle where `en` is 1 and `seed_ld` is 0, both registers take exactly one step, whatever the selector bit is.
- R4: When an enabled cycle sees selector bit 0 equal to 1, `out_vld` is 1 on the next cycle. `out_bit` then equals the data register's bit 0 from before that step.
- R5: When an enabled cycle sees selector bit 0 equal to 0, `out_vld` is 0 on the next cycle. That data bit is discarded.
- R6: When `en` is 0 and `seed_ld` is 0, neither register changes and `out_vld` is 0 on the next cycle.
- R7: A cycle with `seed_ld` at 1 writes `seed_sel` and `seed_dat` into the two registers. This takes priority over `en`. `out_vld` is 0 on the next cycle.
- R8: A seed that is all zeros is replaced by that register's default seed. Each register is handled on its own.
- R9: The state repeats after (2^A − 1)·(2^B − 1) enabled cycles. Within one such period the number of valid strobes is 2^(A−1)·(2^B − 1), which equals the count of 1s that the selector emits over that span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance both registers this cycle |
| seed_ld | input | 1 | Load both seeds this cycle |
| seed_sel | input | SEL_W | Seed for the selector register |
| seed_dat | input | DAT_W | Seed for the data register |
| out_bit | output | 1 | Kept data bit, meaningful when `out_vld` is 1 |
| out_vld | output | 1 | High on cycles that carry a kept bit |

## Verification
The bench builds the generator with a 5-stage selector (taps x^5+x^3+1) and a 7-stage data register (taps x^7+x^6+1). The joint period is then 31·127 = 3937 enabled cycles. At this size a full period can be run, and the kept-bit count over it can be compared with 16·127 = 2032. Every output cycle is compared against a bench model of the stepping rule. This comparison covers gapped enables, reloads during enabled cycles, and zero seeds.

// File: rtl/shrink_pkg.sv
package shrink_pkg;
  typedef struct packed {
    logic vld;
    logic val;
  } kept_bit_t;
endpackage

// File: rtl/shrink_lfsr.sv
module shrink_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'h1D,
  parameter logic [W-1:0] DFLT = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state,
  output logic         lsb
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] nxt_shift;
  logic [W-1:0] seed_fix;
  logic         fb;

  assign fb       = ^(state & TAPS);
  assign seed_fix = (seed == ZERO) ? DFLT : seed;

  for (genvar i = 0; i < W; i++) begin : g_shift
    if (i == W - 1) begin : g_top
      assign nxt_shift[i] = fb;
    end else begin : g_mid
      assign nxt_shift[i] = state[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       state <= DFLT;
    else if (load) state <= seed_fix;
    else if (step) state <= nxt_shift;
  end

  assign lsb = state[0];
endmodule

// File: rtl/shrink_decim.sv
module shrink_decim
  import shrink_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step,
  input  logic      load,
  input  logic      sel_bit,
  input  logic      dat_bit,
  output kept_bit_t kept
);
  always_ff @(posedge clk) begin
    if (rst) begin
      kept <= '0;
    end else begin
      kept.vld <= step && !load && sel_bit;
      if (step && !load && sel_bit) kept.val <= dat_bit;
    end
  end
endmodule

// File: rtl/shrink_gen.sv
module shrink_gen
  import shrink_pkg::*;
#(
  parameter int               SEL_W    = 61,
  parameter int               DAT_W    = 67,
  parameter logic [SEL_W-1:0] SEL_TAPS = 61'h18003,
  parameter logic [DAT_W-1:0] DAT_TAPS = 67'h603,
  parameter logic [SEL_W-1:0] SEL_SEED = 61'h1A2B3C4D,
  parameter logic [DAT_W-1:0] DAT_SEED = 67'h5E6F7081
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             seed_ld,
  input  logic [SEL_W-1:0] seed_sel,
  input  logic [DAT_W-1:0] seed_dat,
  output logic             out_bit,
  output logic             out_vld
);
  logic [SEL_W-1:0] sel_q;
  logic [DAT_W-1:0] dat_q;
  logic             sel_lsb, dat_lsb;
  kept_bit_t        kept;

  shrink_lfsr #(.W(SEL_W), .TAPS(SEL_TAPS), .DFLT(SEL_SEED)) u_sel (
    .clk(clk), .rst(rst), .step(en), .load(seed_ld),
    .seed(seed_sel), .state(sel_q), .lsb(sel_lsb)
  );

  shrink_lfsr #(.W(DAT_W), .TAPS(DAT_TAPS), .DFLT(DAT_SEED)) u_dat (
    .clk(clk), .rst(rst), .step(en), .load(seed_ld),
    .seed(seed_dat), .state(dat_q), .lsb(dat_lsb)
  );

  shrink_decim u_dec (
    .clk(clk), .rst(rst), .step(en), .load(seed_ld),
    .sel_bit(sel_lsb), .dat_bit(dat_lsb), .kept(kept)
  );

  assign out_bit = kept.val;
  assign out_vld = kept.vld;
endmodule

// File: rtl/shrink_gen_chk.sv
module shrink_gen_chk #(
  parameter int SW = 61,
  parameter int DW = 67
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          seed_ld,
  input logic          out_bit,
  input logic          out_vld,
  input logic [SW-1:0] sel_q,
  input logic [DW-1:0] dat_q
);
  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !seed_ld && sel_q[0]) |=> (out_vld && out_bit == $past(dat_q[0])));

  p_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !seed_ld && !sel_q[0]) |=> !out_vld);

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!en && !seed_ld) |=> (!out_vld && $stable(sel_q) && $stable(dat_q)));

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    seed_ld |=> !out_vld);

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !seed_ld) |=> (sel_q[SW-2:0] == $past(sel_q[SW-1:1]) &&
                          dat_q[DW-2:0] == $past(dat_q[DW-1:1])));

  p_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    (sel_q != '0 && dat_q != '0));
endmodule

bind shrink_gen shrink_gen_chk #(.SW(SEL_W), .DW(DAT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .seed_ld(seed_ld),
  .out_bit(out_bit), .out_vld(out_vld), .sel_q(sel_q), .dat_q(dat_q)
);

// File: tb/shrink_gen_test.sv
module shrink_gen_test;
  localparam int SW = 5;
  localparam int DW = 7;
  localparam logic [SW-1:0] ST = 5'b00101;
  localparam logic [DW-1:0] DT = 7'b0000011;
  localparam logic [SW-1:0] SD = 5'h09;
  localparam logic [DW-1:0] DD = 7'h21;
  localparam int PERIOD = ((1 << SW) - 1) * ((1 << DW) - 1);
  localparam int KEPT   = (1 << (SW - 1)) * ((1 << DW) - 1);
  localparam int NV = 6;
  // entry: {seed_sel, seed_dat, cycles, enable pattern}
  localparam logic [23:0] VEC [NV] = '{
    {5'h01, 7'h01, 8'd60, 4'hF},
    {5'h1F, 7'h7F, 8'd60, 4'hF},
    {5'h0A, 7'h55, 8'd60, 4'h5},
    {5'h13, 7'h2C, 8'd60, 4'h7},
    {5'h00, 7'h00, 8'd40, 4'hF},
    {5'h00, 7'h33, 8'd40, 4'h9}
  };

  logic clk = 0, rst = 1, en = 0, seed_ld = 0;
  logic [SW-1:0] seed_sel = '0;
  logic [DW-1:0] seed_dat = '0;
  logic out_bit, out_vld;
  logic [SW-1:0] m_sel;
  logic [DW-1:0] m_dat;
  int errors = 0, checks = 0, vcount = 0;

  always #5 clk = ~clk;

  shrink_gen #(.SEL_W(SW), .DAT_W(DW), .SEL_TAPS(ST), .DAT_TAPS(DT),
               .SEL_SEED(SD), .DAT_SEED(DD)) uut (
    .clk(clk), .rst(rst), .en(en), .seed_ld(seed_ld),
    .seed_sel(seed_sel), .seed_dat(seed_dat),
    .out_bit(out_bit), .out_vld(out_vld)
  );

  task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // one cycle from a negedge to the next, with the model updated per R2..R8
  task automatic cyc(input logic e, input logic l, input logic [SW-1:0] ss,
                     input logic [DW-1:0] sd, input string rq);
    logic ev, eb;
    en = e; seed_ld = l; seed_sel = ss; seed_dat = sd;
    ev = 1'b0; eb = 1'b0;
    if (l) begin
      m_sel = (ss == '0) ? SD : ss;
      m_dat = (sd == '0) ? DD : sd;
    end else if (e) begin
      ev = m_sel[0]; eb = m_dat[0];
      m_sel = {^(m_sel & ST), m_sel[SW-1:1]};
      m_dat = {^(m_dat & DT), m_dat[DW-1:1]};
    end
    @(posedge clk); @(negedge clk);
    check({rq, " vld"}, {7'd0, out_vld}, {7'd0, ev});
    if (ev) begin
      check({rq, " bit"}, {7'd0, out_bit}, {7'd0, eb});
      vcount++;
    end
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 vld in reset", {7'd0, out_vld}, 8'd0);
    rst = 0;
    m_sel = SD; m_dat = DD;
    // R1: default seeds visible through the kept stream
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, '0, '0, "R1/R3/R4/R5 default");

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      cyc(1'b1, 1'b1, VEC[v][23:19], VEC[v][18:12], "R7/R8 load");
      for (int i = 0; i < int'(VEC[v][11:4]); i++)
        cyc(VEC[v][i % 4], 1'b0, '0, '0, "R2/R4/R5/R6 table");
    end

    // R6: long idle, then the stream resumes where the model stopped
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 5'h1F, 7'h7F, "R6 idle");
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, '0, '0, "R6 resume");

    // R7: back-to-back loads with enable high
    cyc(1'b1, 1'b1, 5'h11, 7'h22, "R7 load a");
    cyc(1'b1, 1'b1, 5'h03, 7'h44, "R7 load b");
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, '0, '0, "R7 after load");

    // R8: only selector seed zero
    cyc(1'b0, 1'b1, 5'h00, 7'h5A, "R8 sel zero");
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, '0, '0, "R8 run");

    // R9: a full joint period
    cyc(1'b0, 1'b1, 5'h07, 7'h19, "R9 load");
    vcount = 0;
    for (int i = 0; i < PERIOD; i++) cyc(1'b1, 1'b0, '0, '0, "R9 period");
    check("R9 kept count lo", vcount[7:0], KEPT[7:0]);
    check("R9 kept count hi", vcount[15:8], KEPT[15:8]);
    check("R9 state back sel", {3'd0, m_sel}, 8'h07);
    check("R9 state back dat", {1'd0, m_dat}, 8'h19);
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, '0, '0, "R9 wrap");

    // R1: reset mid-run restores defaults
    rst = 1; en = 1;
    @(posedge clk); @(negedge clk);
    check("R1 vld in reset", {7'd0, out_vld}, 8'd0);
    rst = 0; m_sel = SD; m_dat = DD;
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, '0, '0, "R1 after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule